// File: doc/BRIEF.md
# Two-Wire Bus Serial Clock Timing Generator

This block produces the serial clock of a two-wire bus master. A prescaler turns the functional clock into a slower internal tick. A single phase counter then times every part of a transfer in those ticks: the start condition, each low and high half of a data clock, repeated starts and the stop condition. The counter is loaded with durations taken from two configuration words, one for the low time and one for the high time. Both lines are driven open-drain. The block pulls SCL low through `scl_oe` and takes over SDA only during start and stop sequences. In every other phase the data engine drives SDA, and it uses the two phase strobes to know when to change a bit and when to sample one.

For high-speed transfers, each configuration word carries a second count in its upper byte. The transfer starts with fast-mode timing. Once the data engine signals that the master code is done, the block switches at the next phase boundary to the high-speed counts, which are then counted on every functional clock instead of on the prescaled tick. A slave that holds SCL low stretches the high phase. High-time counting waits until the synchronized line reads high.

Top module: `scl_timing_gen`

## Requirements
- R1: Outside high-speed timing, one internal tick lasts `presc`+1 functional clocks, so every phase lasts its tick count times (`presc`+1) clocks.
- R2: A data low phase lasts (low count + 7) ticks. Two low phases back to back make one continuous low run: a stop after a low phase, or a stop taken right after a start.
- R3: A data high phase lasts (high count + 5) ticks when no slave stretches the clock.
- R4: In both `lo_cfg` and `hi_cfg`, bits 7:0 hold the fast-mode count and bits 15:8 hold the high-speed count.
- R5: A `hs_go` pulse while `hs_mode` is 1 takes effect at the next phase boundary and raises `hs_on`. From then on the high-speed counts apply, one tick per functional clock, until the bus returns to idle. While `hs_mode` is 0, `hs_go` has no effect.
- R6: A start condition runs in three steps. First SCL is released and SDA is held released for one high time. Then SDA is pulled low for one high time. Then SCL is pulled low and `start_busy` clears.
- R7: A stop condition runs in four steps. SCL stays low with SDA low for one extra low time. SCL is then released with SDA still low for one high time. SDA is then released and `stop_busy` clears. The line stays under the block's control for one more high time before idle.
- R8: A pending start is always taken before a pending stop. At the end of a low phase with both pending, a repeated start is generated and the stop waits for a later low phase.
- R9: In released-SCL phases the tick count advances only while SCL, synchronized through two flops, reads high.
- R10: `chg_stb` pulses exactly once in each low run, in the middle of the low phase. `smp_stb` pulses once in the middle of each data high phase.
- R11: With `en` low, on the next cycle SCL and SDA are released, both request flags are clear and requests are not accepted.
- R12: A stop request made while idle with no start pending is dropped without any bus activity.
- R13: After reset both lines are released and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable; low holds everything idle |
| hs_mode | input | 1 | High-speed transfer selected |
| hs_go | input | 1 | Pulse: master code finished, switch to high-speed counts |
| start_set | input | 1 | Pulse: request a start or repeated start |
| stop_set | input | 1 | Pulse: request a stop |
| presc | input | PSC_W | Prescaler value; tick every presc+1 clocks |
| lo_cfg | input | 2*CFG_W | Low-time counts: fast-mode [7:0], high-speed [15:8] |
| hi_cfg | input | 2*CFG_W | High-time counts: fast-mode [7:0], high-speed [15:8] |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_own | output | 1 | Block controls SDA (start/stop sequence) |
| sda_low | output | 1 | While owned, 1 pulls SDA low |
| chg_stb | output | 1 | Mid-low strobe: data may change |
| smp_stb | output | 1 | Mid-high strobe: sample data |
| start_busy | output | 1 | Start request pending |
| stop_busy | output | 1 | Stop request pending |
| hs_on | output | 1 | High-speed counts in use |

## Verification
The embedded assertions check the following on every cycle. Disabling releases the lines and clears the requests. A stop sequence never begins while a start is pending. `start_busy` clears only as SCL is pulled low. The phase counter stays frozen while a released SCL still reads low. `hs_on` rises only on a phase boundary. Exact phase lengths are shown only by the bench's scenarios: prescaled fast-mode, the switch to high speed, the merged low runs of stops, repeated starts and a stretched high phase. The same is true of the start and stop sequencing and of the dropped and ignored requests.

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int PSC_W = 8,
  parameter int CFG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               hs_mode,
  input  logic               hs_go,
  input  logic               start_set,
  input  logic               stop_set,
  input  logic [PSC_W-1:0]   presc,
  input  logic [2*CFG_W-1:0] lo_cfg,
  input  logic [2*CFG_W-1:0] hi_cfg,
  input  logic               scl_in,
  output logic               scl_oe,
  output logic               sda_own,
  output logic               sda_low,
  output logic               chg_stb,
  output logic               smp_stb,
  output logic               start_busy,
  output logic               stop_busy,
  output logic               hs_on
);

  localparam int DW = CFG_W + 1;
  localparam logic [DW-1:0] LO_ADD = DW'(7);
  localparam logic [DW-1:0] HI_ADD = DW'(5);

  typedef enum logic [2:0] {IDLE, ST_SU, ST_HD, LOW, HIGH, SP_LO, SP_SU, SP_BUF} st_t;

  st_t st, st_nx;
  logic [PSC_W-1:0] pre_cnt;
  logic [DW-1:0]    cnt;
  logic             s1, s2;
  logic             hs_pend;

  wire [CFG_W-1:0] lo_sel = hs_on ? lo_cfg[2*CFG_W-1:CFG_W] : lo_cfg[CFG_W-1:0];
  wire [CFG_W-1:0] hi_sel = hs_on ? hi_cfg[2*CFG_W-1:CFG_W] : hi_cfg[CFG_W-1:0];
  wire [DW-1:0]    lo_dur = {1'b0, lo_sel} + LO_ADD;
  wire [DW-1:0]    hi_dur = {1'b0, hi_sel} + HI_ADD;

  wire released = st inside {ST_SU, ST_HD, HIGH, SP_SU, SP_BUF};
  wire low_ph   = (st == LOW) || (st == SP_LO);
  wire [DW-1:0] dur = low_ph ? lo_dur : hi_dur;

  wire pre_tick = (pre_cnt == presc);
  wire tick     = hs_on | pre_tick;
  wire adv      = (st != IDLE) && tick && (!released || s2);
  wire done     = adv && (cnt == dur - DW'(1));
  wire mid      = adv && (cnt == (dur >> 1));

  always_comb begin
    st_nx = st;
    case (st)
      IDLE:   if (start_busy) st_nx = ST_SU;
      ST_SU:  if (done) st_nx = ST_HD;
      ST_HD:  if (done) st_nx = LOW;
      LOW:    if (done) st_nx = start_busy ? ST_SU : (stop_busy ? SP_LO : HIGH);
      HIGH:   if (done) st_nx = LOW;
      SP_LO:  if (done) st_nx = SP_SU;
      SP_SU:  if (done) st_nx = SP_BUF;
      SP_BUF: if (done) st_nx = IDLE;
      default: st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= scl_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      pre_cnt    <= '0;
      cnt        <= '0;
      start_busy <= 1'b0;
      stop_busy  <= 1'b0;
      hs_on      <= 1'b0;
      hs_pend    <= 1'b0;
    end else if (!en) begin
      st         <= IDLE;
      pre_cnt    <= '0;
      cnt        <= '0;
      start_busy <= 1'b0;
      stop_busy  <= 1'b0;
      hs_on      <= 1'b0;
      hs_pend    <= 1'b0;
    end else begin
      st <= st_nx;

      if (st == IDLE || pre_tick) pre_cnt <= '0;
      else                        pre_cnt <= pre_cnt + PSC_W'(1);

      if (st == IDLE || done) cnt <= '0;
      else if (adv)           cnt <= cnt + DW'(1);

      if (st_nx == IDLE) begin
        hs_on   <= 1'b0;
        hs_pend <= 1'b0;
      end else if (done) begin
        hs_on   <= hs_on | hs_pend;
        hs_pend <= hs_go & hs_mode;
      end else if (hs_go && hs_mode) begin
        hs_pend <= 1'b1;
      end

      if (start_set)                 start_busy <= 1'b1;
      else if (st == ST_HD && done)  start_busy <= 1'b0;

      if (stop_set)                                        stop_busy <= 1'b1;
      else if ((st == SP_SU && done) ||
               (st == IDLE && !start_busy))                stop_busy <= 1'b0;
    end
  end

  assign scl_oe  = low_ph;
  assign sda_own = st inside {ST_SU, ST_HD, SP_LO, SP_SU, SP_BUF};
  assign sda_low = st inside {ST_HD, SP_LO, SP_SU};
  assign chg_stb = (st == LOW) && mid;
  assign smp_stb = (st == HIGH) && mid;

  // R11
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_own && !start_busy && !stop_busy));

  // R8
  start_before_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == SP_LO) |-> !$past(start_busy));

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_busy) && $past(en)) |-> scl_oe);

  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && released && !s2) |=> $stable(cnt));

  // R5
  hs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(done));

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  localparam int CLK_P = 10;
  localparam int P  = 4;
  localparam int FL = (10 + 7) * P;
  localparam int FH = (6 + 5) * P;
  localparam int HL = 3 + 7;
  localparam int HH = 2 + 5 + 2;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, hs_mode = 1'b0, hs_go = 1'b0;
  logic start_set = 1'b0, stop_set = 1'b0, ext_hold = 1'b0;
  logic [7:0]  presc = 8'(P - 1);
  logic [15:0] lo_cfg = {8'd3, 8'd10};
  logic [15:0] hi_cfg = {8'd2, 8'd6};
  logic scl_in, scl_oe, sda_own, sda_low, chg_stb, smp_stb, start_busy, stop_busy, hs_on;

  assign scl_in = !scl_oe && !ext_hold;

  always #(CLK_P/2) clk = ~clk;

  scl_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .hs_mode(hs_mode), .hs_go(hs_go),
    .start_set(start_set), .stop_set(stop_set), .presc(presc),
    .lo_cfg(lo_cfg), .hi_cfg(hi_cfg), .scl_in(scl_in),
    .scl_oe(scl_oe), .sda_own(sda_own), .sda_low(sda_low),
    .chg_stb(chg_stb), .smp_stb(smp_stb), .start_busy(start_busy),
    .stop_busy(stop_busy), .hs_on(hs_on));

  int n_chk = 0, n_bad = 0;
  int q_kind[$];
  int q_len[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int len, input string tag);
    q_kind.push_back(kind);
    q_len.push_back(len);
    q_tag.push_back(tag);
  endtask

  task automatic compare(input int kind, input int len);
    if (q_len.size() == 0) begin
      check(1'b0, "unexpected run", len, 0);
    end else begin
      int ek = q_kind.pop_front();
      int el = q_len.pop_front();
      string et = q_tag.pop_front();
      check(ek == kind && el == len, et, len, el);
    end
  endtask

  bit mon_on = 1'b0;
  logic prev_oe = 1'b0;
  int run_len = 0, chg_n = 0;
  bit smp_seen = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (scl_oe == prev_oe) begin
        run_len++;
        if (smp_stb) smp_seen = 1'b1;
        if (chg_stb) chg_n++;
      end else begin
        if (prev_oe && en) begin
          compare(0, run_len);
          check(chg_n == 1, "R10 chg per low", chg_n, 1);
        end else if (!prev_oe && smp_seen) begin
          compare(1, run_len);
        end
        prev_oe  = scl_oe;
        run_len  = 1;
        smp_seen = smp_stb;
        chg_n    = chg_stb ? 1 : 0;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_set = 1'b1;
    @(negedge clk) start_set = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_set = 1'b1;
    @(negedge clk) stop_set = 1'b0;
  endtask

  task automatic wait_chg(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!chg_stb);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (stop_busy || start_busy);
    repeat (150) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R13
    check(!scl_oe && !sda_own && !start_busy && !stop_busy, "R13 reset", int'(scl_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // Scenario A: R1 R2 R3 fast-mode clocks, R6 start, R7 stop
    push(0, FL, "R1 R2 low"); push(1, FH, "R3 high");
    push(0, FL, "R2 low");    push(1, FH, "R3 high");
    push(0, 2*FL, "R7 stop low run");
    pulse_start();
    do @(negedge clk); while (!sda_low);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!scl_oe);
    check(cnt == FH, "R6 start hold", cnt, FH);
    check(!start_busy, "R6 start_busy clear", int'(start_busy), 0);
    wait_chg(3);
    pulse_stop();
    do @(negedge clk); while (scl_oe);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (sda_low);
    check(cnt == FH, "R7 stop setup", cnt, FH);
    check(!stop_busy, "R7 stop_busy clear", int'(stop_busy), 0);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (sda_own);
    check(cnt == FH, "R7 bus free", cnt, FH);
    wait_idle();

    // Scenario B: R8 start and stop together from idle
    push(0, 2*FL, "R8 start then stop");
    @(negedge clk) begin start_set = 1'b1; stop_set = 1'b1; end
    @(negedge clk) begin start_set = 1'b0; stop_set = 1'b0; end
    do @(negedge clk); while (start_busy);
    check(stop_busy, "R8 stop waits", int'(stop_busy), 1);
    wait_idle();

    // Scenario C: R8 both pending at end of low -> repeated start first
    push(0, FL, "R2 low"); push(1, FH, "R3 high");
    push(0, FL, "R8 low before restart");
    push(0, 2*FL, "R8 stop after restart");
    pulse_start();
    wait_chg(2);
    @(negedge clk) begin start_set = 1'b1; stop_set = 1'b1; end
    @(negedge clk) begin start_set = 1'b0; stop_set = 1'b0; end
    do @(negedge clk); while (start_busy);
    check(stop_busy && scl_oe, "R8 restart before stop", int'(stop_busy), 1);
    wait_idle();

    // Scenario D: R4 R5 high-speed switch
    hs_mode = 1'b1;
    push(0, FL, "R5 fast low before switch");
    push(1, HH, "R4 R9 hs high");
    push(0, HL, "R4 hs low");
    push(1, HH, "R4 hs high");
    push(0, 2*HL, "R5 R7 hs stop low run");
    pulse_start();
    wait_chg(1);
    @(negedge clk) hs_go = 1'b1;
    @(negedge clk) hs_go = 1'b0;
    check(!hs_on, "R5 switch waits for boundary", int'(hs_on), 0);
    wait_chg(1);
    check(hs_on, "R5 hs_on", int'(hs_on), 1);
    wait_chg(1);
    pulse_stop();
    wait_idle();
    check(!hs_on, "R5 hs_on cleared in idle", int'(hs_on), 0);
    hs_mode = 1'b0;

    // Scenario E: R5 hs_go ignored without hs_mode
    push(0, FL, "R5 low"); push(1, FH, "R5 high stays fast");
    push(0, 2*FL, "R5 stop low run");
    pulse_start();
    wait_chg(1);
    @(negedge clk) hs_go = 1'b1;
    @(negedge clk) hs_go = 1'b0;
    wait_chg(1);
    check(!hs_on, "R5 ignored", int'(hs_on), 0);
    pulse_stop();
    wait_idle();

    // Scenario F: R9 clock stretching
    push(0, FL, "R2 low");
    push(1, 64, "R9 stretched high");
    push(0, 2*FL, "R7 stop low run");
    pulse_start();
    wait_chg(1);
    ext_hold = 1'b1;
    do @(negedge clk); while (scl_oe);
    repeat (20) @(negedge clk);
    ext_hold = 1'b0;
    wait_chg(1);
    pulse_stop();
    wait_idle();

    // Scenario G: R12 stop alone in idle
    pulse_stop();
    repeat (2) @(negedge clk);
    check(!stop_busy, "R12 stop dropped", int'(stop_busy), 0);
    cnt = 0;
    repeat (50) begin @(negedge clk); if (scl_oe || sda_own) cnt++; end
    check(cnt == 0, "R12 no bus activity", cnt, 0);

    // Scenario H: R11 disable mid-transfer
    pulse_start();
    wait_chg(1);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check(!scl_oe && !sda_own && !start_busy, "R11 released", int'(scl_oe), 0);
    pulse_start();
    @(negedge clk);
    check(!start_busy, "R11 request refused", int'(start_busy), 0);
    repeat (5) @(negedge clk);
    en = 1'b1;
    cnt = 0;
    repeat (30) begin @(negedge clk); if (scl_oe || sda_own) cnt++; end
    check(cnt == 0, "R11 stays idle", cnt, 0);

    repeat (20) @(negedge clk);
    check(q_len.size() == 0, "scoreboard drained", q_len.size(), 0);
    summary();
  end
endmodule